// File: doc/BRIEF.md
# Summed-Audio Monitor Bit Generator

This block mixes a transmit audio word and a receive audio word into one sample. It turns that sample into a single-bit, CMOS-level monitor signal that an external RC filter can smooth into call-progress audio. Three encodings are available:

- a first-order delta-sigma bitstream, updated every clock;
- a center-aligned pulse-width signal with a 1024-clock frame;
- an edge-timed pulse-width signal with a 512-clock frame. Its rising edge moves with the amplitude, and every frame starts low.

A separate enable turns the output off. The reserved mode code also turns the output off.

The core is a four-state machine, and the state is chosen directly from the enable and mode inputs:

- `ST_OFF`: output held low, no sample requests.
- `ST_DSM`: delta-sigma encoding.
- `ST_CTR`: center-aligned pulse width.
- `ST_EDG`: edge-timed pulse width.

The state machine has five transitions:

- `GO_OFF`: taken when the enable is 0 or the mode is 11.
- `GO_DSM`: taken for mode 00.
- `GO_CTR`: taken for mode 01.
- `GO_EDG`: taken for mode 10.
- `STAY`: taken when the decoded state equals the current one.

Any transition into a different state is an entry. An entry clears the frame counter and the modulator accumulator, and it captures a fresh sample.

The sample-request strobe marks each cycle whose closing clock edge captures `tx_samp` and `rx_samp`. The source must hold both words valid while the strobe is high.

Top module: `audio_pwm_gen`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `pwm_out` is 0 and the state is `ST_OFF`.
- R2: The captured sample is u = sat16(tx + rx) + 32768, where the sum is taken as two's-complement with 17 bits and clamped to [-32768, 32767]. So 7FFF+7FFF gives u = FFFF, 8000+8000 gives u = 0000, and 7FFF+8000 gives u = 7FFF.
- R3: With `en` = 0, or with `mode` = 11, `pwm_out` is 0 from the next cycle on and `samp_req` is 0.
- R4: Mode 01 uses a 1024-cycle frame, numbered k = 0..1023 from the first cycle after capture. With h = u>>6 and lead = (1024-h)>>1, `pwm_out` is 1 exactly when lead <= k < lead+h.
- R5: Mode 10 uses a 512-cycle frame. With h = u>>7, `pwm_out` is 1 exactly when k >= 512-h, so cycle k = 0 of every frame is low.
- R6: Mode 00 adds u to a 16-bit accumulator on every clock and outputs the carry. `samp_req` is 1 on every cycle. Over the first K cycles after entry, the number of ones equals floor((K-1)·u/65536).
- R7: `samp_req` is 1 in the entry cycle and in the last cycle (k = N-1) of each pulse-width frame, and 0 otherwise. Samples are taken only at those edges, so input changes in the middle of a frame have no effect on that frame.
- R8: A mode change restarts the frame at k = 0 and clears the accumulator. For example, entering mode 00 with u = 8000 gives the output pattern 0,0,1,0,1,0,1,0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | High-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Output enable |
| mode | input | 2 | Encoding select: 00 delta-sigma, 01 center PWM, 10 edge PWM, 11 off |
| tx_samp | input | 16 | Transmit audio, two's complement |
| rx_samp | input | 16 | Receive audio, two's complement |
| pwm_out | output | 1 | Monitor bit |
| samp_req | output | 1 | High in a cycle whose closing edge captures the samples |

## Verification
Both pulse-width modes are driven with mid-scale, full-scale and clamped sums. These patterns separate a wrong pulse position from a wrong width, and they reveal a missing saturation or a missing offset conversion. Input words are changed halfway through a frame, which shows whether capture happens only at frame boundaries. The delta-sigma mode is run with random constant levels and checked against an exact count of ones. It is also entered with a mid-scale level straight after an earlier run, which exposes an accumulator that was not cleared. Random seeded mode and sample mixes, and a switch from one mode to another in the middle of a frame, cover frame restart.

// File: rtl/apwm_pkg.sv
package apwm_pkg;

    typedef enum logic [1:0] {
        ST_OFF = 2'd0,
        ST_DSM = 2'd1,
        ST_CTR = 2'd2,
        ST_EDG = 2'd3
    } apwm_state_t;

    // Transition decode: GO_OFF / GO_DSM / GO_CTR / GO_EDG
    function automatic apwm_state_t pick_state(input logic en, input logic [1:0] mode);
        apwm_state_t s;
        if (!en) begin
            s = ST_OFF;
        end else begin
            unique case (mode)
                2'b00:   s = ST_DSM;
                2'b01:   s = ST_CTR;
                2'b10:   s = ST_EDG;
                default: s = ST_OFF;
            endcase
        end
        return s;
    endfunction

endpackage

// File: rtl/apwm_mixer.sv
module apwm_mixer #(
    parameter int W = 16
) (
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] level
);
    logic [W:0]   sum_x;
    logic [W-1:0] clamped;
    logic         ovf;

    always_comb begin
        sum_x = {a_in[W-1], a_in} + {b_in[W-1], b_in};
        ovf   = sum_x[W] ^ sum_x[W-1];
        if (ovf) begin
            clamped = sum_x[W] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
        end else begin
            clamped = sum_x[W-1:0];
        end
        // offset binary: flip the sign bit
        level = {~clamped[W-1], clamped[W-2:0]};
    end
endmodule

// File: rtl/apwm_dsm.sv
module apwm_dsm #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         run,
    input  logic [W-1:0] level,
    output logic         bit_out
);
    logic [W-1:0] acc_q;
    logic [W:0]   acc_sum;

    always_comb begin
        acc_sum = {1'b0, acc_q} + {1'b0, level};
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            acc_q   <= '0;
            bit_out <= 1'b0;
        end else if (run) begin
            acc_q   <= acc_sum[W-1:0];
            bit_out <= acc_sum[W];
        end
    end
endmodule

// File: rtl/apwm_frame_timer.sv
module apwm_frame_timer
    import apwm_pkg::*;
#(
    parameter int CTR_N = 1024,
    parameter int EDG_N = 512,
    localparam int CW   = $clog2(CTR_N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  apwm_state_t   st_q,
    output logic [CW-1:0] cnt,
    output logic          last
);
    localparam logic [CW-1:0] CTR_LAST = CW'(CTR_N - 1);
    localparam logic [CW-1:0] EDG_LAST = CW'(EDG_N - 1);

    always_comb begin
        unique case (st_q)
            ST_OFF: last = 1'b0;
            ST_DSM: last = 1'b1;
            ST_CTR: last = (cnt == CTR_LAST);
            ST_EDG: last = (cnt == EDG_LAST);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (st_q == ST_OFF || st_q == ST_DSM || last) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/apwm_shaper.sv
module apwm_shaper
    import apwm_pkg::*;
#(
    parameter int W     = 16,
    parameter int CTR_N = 1024,
    parameter int EDG_N = 512,
    localparam int CW   = $clog2(CTR_N),
    localparam int EW   = $clog2(EDG_N)
) (
    input  apwm_state_t   st_q,
    input  logic [CW-1:0] cnt,
    input  logic [W-1:0]  level,
    input  logic          dsm_bit,
    output logic          pin
);
    logic [CW:0] cnt_x;
    logic [CW:0] hc;
    logic [CW:0] lead_full;
    logic [CW:0] lead;
    logic [CW:0] he;
    logic [CW:0] rise;
    logic        ctr_hi;
    logic        edg_hi;

    always_comb begin
        cnt_x     = {1'b0, cnt};
        hc        = {1'b0, level[W-1 -: CW]};
        lead_full = (CW+1)'(CTR_N) - hc;
        lead      = lead_full >> 1;
        ctr_hi    = (cnt_x >= lead) && (cnt_x < lead + hc);
        he        = (CW+1)'(level[W-1 -: EW]);
        rise      = (CW+1)'(EDG_N) - he;
        edg_hi    = (cnt_x >= rise);
    end

    always_comb begin
        unique case (st_q)
            ST_OFF: pin = 1'b0;
            ST_DSM: pin = dsm_bit;
            ST_CTR: pin = ctr_hi;
            ST_EDG: pin = edg_hi;
        endcase
    end
endmodule

// File: rtl/audio_pwm_gen.sv
module audio_pwm_gen
    import apwm_pkg::*;
#(
    parameter int W     = 16,
    parameter int CTR_N = 1024,
    parameter int EDG_N = 512
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic [1:0]   mode,
    input  logic [15:0]  tx_samp,
    input  logic [15:0]  rx_samp,
    output logic         pwm_out,
    output logic         samp_req
);
    localparam int CW = $clog2(CTR_N);

    apwm_state_t   state_q;
    apwm_state_t   state_n;
    logic          entry;
    logic [CW-1:0] cnt;
    logic          frame_last;
    logic [W-1:0]  mixed;
    logic [W-1:0]  level_q;
    logic          dsm_bit;

    // next state
    always_comb begin
        state_n = pick_state(en, mode);
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_n;
        end
    end

    // outputs of the state machine
    always_comb begin
        entry    = (state_n != state_q);
        samp_req = !rst && (state_n != ST_OFF) && (entry || frame_last);
    end

    apwm_mixer #(.W(W)) u_mix (
        .a_in  (tx_samp[W-1:0]),
        .b_in  (rx_samp[W-1:0]),
        .level (mixed)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            level_q <= '0;
        end else if (samp_req) begin
            level_q <= mixed;
        end
    end

    apwm_frame_timer #(.CTR_N(CTR_N), .EDG_N(EDG_N)) u_tmr (
        .clk  (clk),
        .rst  (rst),
        .clr  (entry),
        .st_q (state_q),
        .cnt  (cnt),
        .last (frame_last)
    );

    apwm_dsm #(.W(W)) u_dsm (
        .clk     (clk),
        .rst     (rst),
        .clr     (entry),
        .run     (state_q == ST_DSM),
        .level   (level_q),
        .bit_out (dsm_bit)
    );

    apwm_shaper #(.W(W), .CTR_N(CTR_N), .EDG_N(EDG_N)) u_shp (
        .st_q    (state_q),
        .cnt     (cnt),
        .level   (level_q),
        .dsm_bit (dsm_bit),
        .pin     (pwm_out)
    );
endmodule

// File: rtl/apwm_checker.sv
module apwm_checker (
    input logic       clk,
    input logic       rst,
    input logic       en,
    input logic [1:0] mode,
    input logic       pwm_out,
    input logic       samp_req
);
    // R1
    reset_low_chk: assert property (@(posedge clk) rst |=> !pwm_out);

    // R3
    off_low_chk: assert property (@(posedge clk) disable iff (rst)
        (!en || mode == 2'b11) |=> !pwm_out);

    // R3
    off_req_chk: assert property (@(posedge clk) disable iff (rst)
        (!en || mode == 2'b11) |-> !samp_req);

    // R5
    edge_start_low_chk: assert property (@(posedge clk) disable iff (rst)
        (samp_req && en && mode == 2'b10) |=> !pwm_out);

    // R6
    dsm_req_chk: assert property (@(posedge clk) disable iff (rst)
        (en && mode == 2'b00 && $past(en && mode == 2'b00)) |-> samp_req);
endmodule

bind audio_pwm_gen apwm_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .en       (en),
    .mode     (mode),
    .pwm_out  (pwm_out),
    .samp_req (samp_req)
);

// File: tb/audio_pwm_gen_bench.sv
module audio_pwm_gen_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b0;
    logic [1:0]  mode = 2'b00;
    logic [15:0] tx = '0;
    logic [15:0] rx = '0;
    logic        pwm_out;
    logic        samp_req;
    int          checks = 0;
    int          fails = 0;

    always #10 clk = ~clk;

    audio_pwm_gen u_audio_pwm_gen (
        .clk(clk), .rst(rst), .en(en), .mode(mode),
        .tx_samp(tx), .rx_samp(rx), .pwm_out(pwm_out), .samp_req(samp_req)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int exp_u(input logic [15:0] a, input logic [15:0] b);
        int s;
        s = int'($signed(a)) + int'($signed(b));
        if (s > 32767) s = 32767;
        if (s < -32768) s = -32768;
        return s + 32768;
    endfunction

    function automatic bit ctr_hi(input int u, input int k);
        int h, lead;
        h = u >> 6;
        lead = (1024 - h) / 2;
        return (k >= lead) && (k < lead + h);
    endfunction

    function automatic bit edg_hi(input int u, input int k);
        return k >= 512 - (u >> 7);
    endfunction

    task automatic go(input bit e, input logic [1:0] m, input logic [15:0] t, input logic [15:0] r);
        @(negedge clk);
        en = e; mode = m; tx = t; rx = r;
        #1;
        if (e && m != 2'b11) chk(samp_req === 1'b1, "R7 entry strobe", int'(samp_req), 1);
        @(negedge clk);
    endtask

    task automatic pwm_frame(input bit is_ctr, input int u, input bit change, input string tag);
        int n, bad, rbad, first;
        bit e;
        n = is_ctr ? 1024 : 512;
        bad = 0; rbad = 0; first = -1;
        for (int k = 0; k < n; k++) begin
            e = is_ctr ? ctr_hi(u, k) : edg_hi(u, k);
            if (pwm_out !== e) begin
                bad++;
                if (first < 0) first = k;
            end
            if (samp_req !== (k == n - 1)) rbad++;
            if (change && k == n / 2) begin
                tx = 16'($urandom);
                rx = 16'($urandom);
            end
            @(negedge clk);
        end
        chk(bad == 0, tag, bad, 0);
        if (bad != 0) $display("  first mismatch at k=%0d, u=%0h", first, u);
        chk(rbad == 0, "R7 strobe only at frame end", rbad, 0);
    endtask

    task automatic dsm_run(input int u, input string tag);
        int ones, rbad;
        ones = 0; rbad = 0;
        for (int k = 0; k < 4096; k++) begin
            if (pwm_out === 1'b1) ones++;
            if (samp_req !== 1'b1) rbad++;
            @(negedge clk);
        end
        chk(ones == (4095 * u) / 65536, tag, ones, (4095 * u) / 65536);
        chk(rbad == 0, "R6 strobe every cycle", rbad, 0);
    endtask

    task automatic off_run(input string tag);
        int hi, rq;
        hi = 0; rq = 0;
        @(negedge clk);
        for (int k = 0; k < 200; k++) begin
            if (pwm_out !== 1'b0) hi++;
            if (samp_req !== 1'b0) rq++;
            tx = 16'($urandom);
            @(negedge clk);
        end
        chk(hi == 0 && rq == 0, tag, hi + rq, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int u, bad, m;
        int seed;
        seed = $urandom(32'h5EED_0042);
        en = 1'b1; mode = 2'b01;
        repeat (3) @(negedge clk);
        chk(pwm_out === 1'b0, "R1 output low in reset", int'(pwm_out), 0);
        rst = 1'b0;
        en = 1'b0;
        @(negedge clk);
        chk(pwm_out === 1'b0, "R1 output low after reset", int'(pwm_out), 0);

        // R3 disabled and reserved mode
        en = 1'b0; mode = 2'b01;
        off_run("R3 disabled output and strobe low");
        en = 1'b1; mode = 2'b11;
        off_run("R3 reserved mode output and strobe low");

        // R4 center PWM, mid-frame change ignored (R7)
        go(0, 2'b00, 16'h0, 16'h0);
        go(1, 2'b01, 16'h1000, 16'h0800);
        pwm_frame(1, 32'h9800, 1, "R4 center pulse, R7 mid-frame change ignored");
        u = exp_u(tx, rx);
        pwm_frame(1, u, 0, "R4 center pulse next frame, R7 captured at boundary");

        // R2 saturation and offset
        go(0, 2'b00, 16'h0, 16'h0);
        go(1, 2'b01, 16'h7FFF, 16'h7FFF);
        pwm_frame(1, 32'hFFFF, 0, "R2 positive saturation");
        go(0, 2'b00, 16'h0, 16'h0);
        go(1, 2'b01, 16'h8000, 16'h8000);
        pwm_frame(1, 0, 0, "R2 negative saturation");
        go(0, 2'b00, 16'h0, 16'h0);
        go(1, 2'b01, 16'h7FFF, 16'h8000);
        pwm_frame(1, 32'h7FFF, 0, "R2 offset binary of -1");

        // R5 edge PWM
        go(0, 2'b00, 16'h0, 16'h0);
        go(1, 2'b10, 16'h2000, 16'h0100);
        pwm_frame(0, 32'hA100, 1, "R5 edge pulse");
        u = exp_u(tx, rx);
        pwm_frame(0, u, 0, "R5 edge pulse next frame");
        go(0, 2'b00, 16'h0, 16'h0);
        go(1, 2'b10, 16'h7FFF, 16'h7FFF);
        pwm_frame(0, 32'hFFFF, 0, "R5 full scale, first cycle low");

        // R8 mode switch mid-frame
        go(0, 2'b00, 16'h0, 16'h0);
        go(1, 2'b01, 16'($urandom), 16'($urandom));
        repeat (300) @(negedge clk);
        go(1, 2'b10, 16'h0C00, 16'hF000);
        u = exp_u(16'h0C00, 16'hF000);
        pwm_frame(0, u, 0, "R8 frame restarts on mode change");

        // R6 delta-sigma density
        go(0, 2'b00, 16'h0, 16'h0);
        go(1, 2'b00, 16'h3A11, 16'h0472);
        dsm_run(exp_u(16'h3A11, 16'h0472), "R6 delta-sigma ones count");

        // R8 accumulator cleared on entry
        go(0, 2'b00, 16'h0, 16'h0);
        go(1, 2'b00, 16'h1234, 16'hEDCC);
        bad = 0;
        for (int k = 0; k < 8; k++) begin
            if (pwm_out !== ((k >= 2) && (k % 2 == 0))) bad++;
            @(negedge clk);
        end
        chk(bad == 0, "R8 accumulator cleared, pattern 0,0,1,0,1,0,1,0", bad, 0);

        // random mixes
        for (int i = 0; i < 6; i++) begin
            m = int'($urandom % 3);
            tx = 16'($urandom);
            rx = 16'($urandom);
            u = exp_u(tx, rx);
            go(0, 2'b00, tx, rx);
            go(1, 2'(m), tx, rx);
            if (m == 0) begin
                dsm_run(u, "R6 random delta-sigma density");
            end else begin
                pwm_frame(m == 1, u, 1, "R4/R5 random pulse frame");
                u = exp_u(tx, rx);
                pwm_frame(m == 1, u, 0, "R7 random next-frame capture");
            end
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule